// File: doc/BRIEF.md
# Branch Target Address Cache

This block is a small direct-mapped cache of branch targets that the fetch stage consults with the current fetch address. In the same cycle it reports three things: whether a branch is known at that address, whether that branch is expected to be taken, and which address to fetch next. Each entry carries a valid flag, an address tag, a target address and a 2-bit direction counter. Low-order instruction address bits, above the word offset, select the entry. The stored tag is compared so that a different branch mapping to the same slot is not mistaken for the stored one.

Branch resolution writes through a single update port. A resolved taken branch that misses claims its slot and evicts whatever was there. A resolved not-taken branch that misses leaves the cache unchanged. A resolved branch that hits steps its counter and, when taken, refreshes the stored target. The lookup is combinational on registered state, so an update becomes visible only from the cycle after it is presented.

Top module: `btac`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses: `lk_hit`=0, `lk_taken`=0, `lk_ctr`=00 and `lk_next_pc`=`fetch_pc`+4.
- R2: A lookup hits only when the selected entry is valid and its stored tag equals the tag of `fetch_pc`. The entry is selected by `fetch_pc[IDX_W+1:2]` and the tag is `fetch_pc[ADDR_W-1:IDX_W+2]`. An address with the same index but a different tag misses.
- R3: `lk_taken` is 1 exactly when the lookup hits and bit 1 of the entry counter is 1. `lk_next_pc` is the stored target when `lk_taken` is 1, and `fetch_pc`+4 otherwise.
- R4: A taken update that misses writes the tag and target, sets valid, and sets the counter to 10 (weakly taken).
- R5: A not-taken update that misses writes nothing. A valid entry already in that slot with another tag is left intact.
- R6: On a hit, a taken update increments the counter, saturating at 11, and a not-taken update decrements it, saturating at 00. The encodings are 11 strongly taken, 10 weakly taken, 01 weakly not taken and 00 strongly not taken.
- R7: A taken update that hits replaces the stored target with `upd_target`. A not-taken update that hits keeps the stored target.
- R8: A taken update that misses on an occupied slot replaces that entry, and the old branch address then misses.
- R9: When an update and a lookup address the same entry in the same cycle, the lookup returns the contents from before the update. The new contents are seen from the next cycle.
- R10: While `upd_valid` is 0, the update port changes no entry.
- R11: `lk_ctr` shows the counter of the selected entry on a hit and 00 on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | ADDR_W | Address looked up this cycle |
| lk_hit | output | 1 | Lookup found a matching valid entry |
| lk_taken | output | 1 | Lookup predicts the branch taken |
| lk_ctr | output | 2 | Direction counter of the hit entry, 00 on a miss |
| lk_next_pc | output | ADDR_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | ADDR_W | Resolved target address |

## Verification
A wrong internal state appears at the lookup ports in the first cycle after the update that caused it. A bad counter step shows up as a wrong `lk_ctr` value, and once it crosses the taken/not-taken boundary it also shows as a flipped `lk_taken` and a wrong `lk_next_pc`. A tag or valid error shows as a false hit on an aliasing address, or as a lost entry that should still hit. The bench therefore reads each affected address right after each update. It walks the counter through both saturation ends and exercises conflicts on a shared slot. It also samples before and after the clock edge where a lookup and an update meet.

// File: rtl/btac_pkg.sv
package btac_pkg;

    localparam int unsigned OFS_W      = 2;
    localparam int unsigned INSTR_STEP = 4;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_t;

    function automatic ctr_t ctr_step(input ctr_t cur, input logic went);
        ctr_t nxt;
        nxt = cur;
        if (went) begin
            if (cur != CTR_ST) nxt = ctr_t'(cur + 2'd1);
        end else begin
            if (cur != CTR_SNT) nxt = ctr_t'(cur - 2'd1);
        end
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/btac_addr_split.sv
module btac_addr_split #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 4,
    localparam int unsigned TAG_W = ADDR_W - IDX_W - btac_pkg::OFS_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    logic [btac_pkg::OFS_W-1:0] unused_ofs;

    always_comb begin
        idx        = addr[IDX_W+btac_pkg::OFS_W-1:btac_pkg::OFS_W];
        tag        = addr[ADDR_W-1:IDX_W+btac_pkg::OFS_W];
        unused_ofs = addr[btac_pkg::OFS_W-1:0];
    end
endmodule

// File: rtl/btac_entry_array.sv
module btac_entry_array
    import btac_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned ADDR_W  = 32,
    localparam int unsigned IDX_W  = $clog2(ENTRIES),
    localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    // lookup read port
    input  logic [IDX_W-1:0]  ra_idx,
    output logic              ra_valid,
    output logic [TAG_W-1:0]  ra_tag,
    output logic [ADDR_W-1:0] ra_target,
    output ctr_t              ra_ctr,
    // update read port
    input  logic [IDX_W-1:0]  rb_idx,
    output logic              rb_valid,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [ADDR_W-1:0] rb_target,
    output ctr_t              rb_ctr,
    // write port
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_target,
    input  ctr_t              wr_ctr
);
    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] target;
        ctr_t              ctr;
    } entry_t;

    entry_t             ent_arr [ENTRIES];
    logic [ENTRIES-1:0] valid_vec;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(e);
        entry_t ent_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q.valid <= 1'b0;
            end else if (wr_en && (wr_idx == MY_IDX)) begin
                ent_q.valid  <= 1'b1;
                ent_q.tag    <= wr_tag;
                ent_q.target <= wr_target;
                ent_q.ctr    <= wr_ctr;
            end
        end

        assign ent_arr[e]   = ent_q;
        assign valid_vec[e] = ent_q.valid;
    end

    always_comb begin
        ra_valid  = ent_arr[ra_idx].valid;
        ra_tag    = ent_arr[ra_idx].tag;
        ra_target = ent_arr[ra_idx].target;
        ra_ctr    = ent_arr[ra_idx].ctr;
        rb_valid  = ent_arr[rb_idx].valid;
        rb_tag    = ent_arr[rb_idx].tag;
        rb_target = ent_arr[rb_idx].target;
        rb_ctr    = ent_arr[rb_idx].ctr;
    end

    // R10: a cycle without a write leaves every valid flag as it was
    p_idle_keeps_valid_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(valid_vec));

    // R4/R8: a write always leaves its slot valid
    p_write_sets_valid_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> valid_vec[$past(wr_idx)]);
endmodule

// File: rtl/btac_update_ctl.sv
module btac_update_ctl
    import btac_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned TAG_W  = 26
) (
    input  logic              upd_valid,
    input  logic              upd_taken,
    input  logic [TAG_W-1:0]  upd_tag,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              cur_valid,
    input  logic [TAG_W-1:0]  cur_tag,
    input  logic [ADDR_W-1:0] cur_target,
    input  ctr_t              cur_ctr,
    output logic              upd_hit,
    output logic              wr_en,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [ADDR_W-1:0] wr_target,
    output ctr_t              wr_ctr
);
    always_comb begin
        upd_hit   = cur_valid && (cur_tag == upd_tag);
        wr_en     = 1'b0;
        wr_tag    = upd_tag;
        wr_target = cur_target;
        wr_ctr    = cur_ctr;
        if (upd_valid) begin
            if (upd_hit) begin
                wr_en  = 1'b1;
                wr_ctr = ctr_step(cur_ctr, upd_taken);
                if (upd_taken) wr_target = upd_target;
            end else if (upd_taken) begin
                wr_en     = 1'b1;
                wr_target = upd_target;
                wr_ctr    = CTR_WT;
            end
        end
    end
endmodule

// File: rtl/btac_lookup.sv
module btac_lookup
    import btac_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned TAG_W  = 26
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [TAG_W-1:0]  pc_tag,
    input  logic              ent_valid,
    input  logic [TAG_W-1:0]  ent_tag,
    input  logic [ADDR_W-1:0] ent_target,
    input  ctr_t              ent_ctr,
    output logic              hit,
    output logic              taken,
    output logic [1:0]        ctr,
    output logic [ADDR_W-1:0] next_pc
);
    logic [ADDR_W-1:0] seq_pc;

    always_comb begin
        seq_pc  = pc + ADDR_W'(INSTR_STEP);
        hit     = ent_valid && (ent_tag == pc_tag);
        taken   = hit && ctr_says_taken(ent_ctr);
        ctr     = hit ? ent_ctr : CTR_SNT;
        next_pc = taken ? ent_target : seq_pc;
    end
endmodule

// File: rtl/btac.sv
module btac
    import btac_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned ADDR_W  = 32,
    localparam int unsigned IDX_W  = $clog2(ENTRIES),
    localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              lk_hit,
    output logic              lk_taken,
    output logic [1:0]        lk_ctr,
    output logic [ADDR_W-1:0] lk_next_pc,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);
    logic [IDX_W-1:0]  f_idx, u_idx;
    logic [TAG_W-1:0]  f_tag, u_tag;

    logic              ra_valid, rb_valid;
    logic [TAG_W-1:0]  ra_tag, rb_tag;
    logic [ADDR_W-1:0] ra_target, rb_target;
    ctr_t              ra_ctr, rb_ctr;

    logic              upd_hit;
    logic              wr_en;
    logic [TAG_W-1:0]  wr_tag;
    logic [ADDR_W-1:0] wr_target;
    ctr_t              wr_ctr;

    btac_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_split_fetch (
        .addr(fetch_pc), .idx(f_idx), .tag(f_tag)
    );

    btac_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_split_upd (
        .addr(upd_pc), .idx(u_idx), .tag(u_tag)
    );

    btac_entry_array #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .rst(rst),
        .ra_idx(f_idx), .ra_valid(ra_valid), .ra_tag(ra_tag),
        .ra_target(ra_target), .ra_ctr(ra_ctr),
        .rb_idx(u_idx), .rb_valid(rb_valid), .rb_tag(rb_tag),
        .rb_target(rb_target), .rb_ctr(rb_ctr),
        .wr_en(wr_en), .wr_idx(u_idx), .wr_tag(wr_tag),
        .wr_target(wr_target), .wr_ctr(wr_ctr)
    );

    btac_update_ctl #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_upd (
        .upd_valid(upd_valid), .upd_taken(upd_taken), .upd_tag(u_tag),
        .upd_target(upd_target),
        .cur_valid(rb_valid), .cur_tag(rb_tag), .cur_target(rb_target),
        .cur_ctr(rb_ctr),
        .upd_hit(upd_hit), .wr_en(wr_en), .wr_tag(wr_tag),
        .wr_target(wr_target), .wr_ctr(wr_ctr)
    );

    btac_lookup #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_look (
        .pc(fetch_pc), .pc_tag(f_tag),
        .ent_valid(ra_valid), .ent_tag(ra_tag), .ent_target(ra_target),
        .ent_ctr(ra_ctr),
        .hit(lk_hit), .taken(lk_taken), .ctr(lk_ctr), .next_pc(lk_next_pc)
    );

    // R1: the first cycle out of reset sees an empty cache
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !lk_hit);

    // R3: a miss always falls through to the sequential address
    p_miss_falls_through_r3: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_next_pc == fetch_pc + ADDR_W'(INSTR_STEP)) && !lk_taken);

    // R4: a taken miss is seen as weakly taken on the next lookup of that address
    p_alloc_weak_r4: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_hit && upd_taken) ##1 (fetch_pc == $past(upd_pc))
        |-> lk_hit && (lk_ctr == 2'b10));

    // R5: a not-taken miss does not create an entry
    p_nt_miss_no_alloc_r5: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_hit && !upd_taken) ##1 (fetch_pc == $past(upd_pc))
        |-> !lk_hit);

    // R6: strongly taken stays strongly taken on another taken outcome
    p_ctr_sat_high_r6: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_hit && upd_taken && rb_ctr == CTR_ST)
        ##1 (fetch_pc == $past(upd_pc)) |-> lk_ctr == 2'b11);

    // R6: strongly not taken stays there on another not-taken outcome
    p_ctr_sat_low_r6: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_hit && !upd_taken && rb_ctr == CTR_SNT)
        ##1 (fetch_pc == $past(upd_pc)) |-> lk_hit && lk_ctr == 2'b00);
endmodule

// File: tb/btac_tb.sv
module btac_tb;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned ADDR_W     = 32;

    localparam logic [31:0] PC_A = 32'h0000_1000;
    localparam logic [31:0] PC_B = 32'h0000_2000; // same slot as PC_A
    localparam logic [31:0] PC_C = 32'h0000_1044;
    localparam logic [31:0] T1   = 32'h0000_8000;
    localparam logic [31:0] T2   = 32'h0000_9000;
    localparam logic [31:0] T3   = 32'h0000_A000;
    localparam logic [31:0] T4   = 32'h0000_B000;
    localparam logic [31:0] T5   = 32'h0000_C000;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] fetch_pc;
    logic              lk_hit, lk_taken;
    logic [1:0]        lk_ctr;
    logic [ADDR_W-1:0] lk_next_pc;
    logic              upd_valid;
    logic [ADDR_W-1:0] upd_pc;
    logic              upd_taken;
    logic [ADDR_W-1:0] upd_target;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    btac #(.ENTRIES(16), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
        .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_ctr(lk_ctr),
        .lk_next_pc(lk_next_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_out(input string req, input logic e_hit,
                             input logic e_tk, input logic [1:0] e_ctr,
                             input logic [31:0] e_next);
        n_cmp++;
        if (lk_hit !== e_hit || lk_taken !== e_tk || lk_ctr !== e_ctr ||
            lk_next_pc !== e_next) begin
            n_bad++;
            $display("FAIL %s pc=%h: got hit=%b tk=%b ctr=%b next=%h, expected hit=%b tk=%b ctr=%b next=%h",
                     req, fetch_pc, lk_hit, lk_taken, lk_ctr, lk_next_pc,
                     e_hit, e_tk, e_ctr, e_next);
        end
    endtask

    task automatic look(input logic [31:0] pc, input string req,
                        input logic e_hit, input logic e_tk,
                        input logic [1:0] e_ctr, input logic [31:0] e_next);
        fetch_pc = pc;
        #1;
        check_out(req, e_hit, e_tk, e_ctr, e_next);
    endtask

    task automatic update(input logic [31:0] pc, input logic tk,
                          input logic [31:0] tgt);
        @(negedge clk);
        upd_valid  = 1'b1;
        upd_pc     = pc;
        upd_taken  = tk;
        upd_target = tgt;
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        look(PC_A, "R1", 1'b0, 1'b0, 2'b00, PC_A + 4);
        look(PC_C, "R1", 1'b0, 1'b0, 2'b00, PC_C + 4);
    endtask

    task automatic t_alloc();
        update(PC_A, 1'b1, T1);
        look(PC_A, "R4", 1'b1, 1'b1, 2'b10, T1);
        look(PC_B, "R2", 1'b0, 1'b0, 2'b00, PC_B + 4);
    endtask

    task automatic t_nt_miss();
        update(PC_B, 1'b0, T4);
        look(PC_B, "R5", 1'b0, 1'b0, 2'b00, PC_B + 4);
        look(PC_A, "R5", 1'b1, 1'b1, 2'b10, T1);
    endtask

    task automatic t_counter();
        update(PC_A, 1'b1, T1);
        update(PC_A, 1'b1, T1);
        look(PC_A, "R6", 1'b1, 1'b1, 2'b11, T1);
        update(PC_A, 1'b0, T1);
        look(PC_A, "R6", 1'b1, 1'b1, 2'b10, T1);
        update(PC_A, 1'b0, T1);
        look(PC_A, "R3", 1'b1, 1'b0, 2'b01, PC_A + 4);
        update(PC_A, 1'b0, T1);
        update(PC_A, 1'b0, T1);
        look(PC_A, "R6", 1'b1, 1'b0, 2'b00, PC_A + 4);
        update(PC_A, 1'b1, T1);
        look(PC_A, "R6", 1'b1, 1'b0, 2'b01, PC_A + 4);
        update(PC_A, 1'b1, T1);
        look(PC_A, "R11", 1'b1, 1'b1, 2'b10, T1);
    endtask

    task automatic t_retarget();
        update(PC_A, 1'b1, T2);
        look(PC_A, "R7", 1'b1, 1'b1, 2'b11, T2);
        update(PC_A, 1'b0, T5);
        look(PC_A, "R7", 1'b1, 1'b1, 2'b10, T2);
        update(PC_A, 1'b1, T2);
        look(PC_A, "R7", 1'b1, 1'b1, 2'b11, T2);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        upd_valid  = 1'b1;
        upd_pc     = PC_A;
        upd_taken  = 1'b1;
        upd_target = T3;
        fetch_pc   = PC_A;
        #1;
        check_out("R9", 1'b1, 1'b1, 2'b11, T2);
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
        check_out("R9", 1'b1, 1'b1, 2'b11, T3);
    endtask

    task automatic t_idle();
        @(negedge clk);
        upd_valid  = 1'b0;
        upd_pc     = PC_C;
        upd_taken  = 1'b1;
        upd_target = T5;
        @(posedge clk);
        @(posedge clk);
        #1;
        look(PC_C, "R10", 1'b0, 1'b0, 2'b00, PC_C + 4);
        look(PC_A, "R10", 1'b1, 1'b1, 2'b11, T3);
    endtask

    task automatic t_replace();
        update(PC_B, 1'b1, T4);
        look(PC_B, "R8", 1'b1, 1'b1, 2'b10, T4);
        look(PC_A, "R8", 1'b0, 1'b0, 2'b00, PC_A + 4);
    endtask

    task automatic t_reset_again();
        do_reset();
        look(PC_B, "R1", 1'b0, 1'b0, 2'b00, PC_B + 4);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst        = 1'b1;
        fetch_pc   = '0;
        upd_valid  = 1'b0;
        upd_pc     = '0;
        upd_taken  = 1'b0;
        upd_target = '0;
        t_reset();
        t_alloc();
        t_nt_miss();
        t_counter();
        t_retarget();
        t_same_cycle();
        t_idle();
        t_replace();
        t_reset_again();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule